// File: doc/BRIEF.md
# Word-Parallel CRC-32 Frame Engine

This block computes the Ethernet CRC-32 over a stream of data words. It consumes one full `DATA_W`-bit word on every clock that carries `valid_i`. The per-clock update is a combinational XOR network generated from the reflected polynomial, so the width can be raised above 32 bits without changing the state. At the start of each frame the register is seeded with all ones. At the end of a frame the block presents the one's complement of the register, which is the frame check value to append.

In check mode the frame is fed in together with its received check word. A correct frame always leaves the same residue in the register, whatever its length, and the block raises `good_o` when it sees that residue. Results appear one clock after the word marked `last_i`, and they are held until the next frame ends.

Top module: `crc32_frame_engine`

## Requirements
- R1: While `rst_ni` is low and right after reset, `crc_valid_o` is 0, `good_o` is 0 and `crc_o` is 0.
- R2: A word with `valid_i` and `start_i` both high seeds the register with 0xFFFFFFFF before that word is folded in. A frame that was left unfinished before it has no effect on the next frame's result.
- R3: The bit stream runs from `data_i[0]` up to `data_i[DATA_W-1]` in each word, so that byte 0 (`data_i[7:0]`) comes first and each byte is taken LSB first. The polynomial is 0x04C11DB7, processed in reflected form. `crc_o` is the one's complement of the final register. One all-zero 32-bit word gives 0x2144DF1C.
- R4: `crc_valid_o` is high for exactly the one cycle after each clock in which `valid_i` and `last_i` are both high.
- R5: In check mode (`check_i`=1 on the last word), a frame whose final word is the `crc_o` value of the preceding words gives `good_o`=1 for any frame length. `crc_o` then reads 0x2144DF1C, the complement of the fixed residue 0xDEBB20E3.
- R6: In check mode, a frame with any single bit flipped in its data or its check word gives `good_o`=0.
- R7: In generate mode (`check_i`=0 on the last word), `good_o` is 0.
- R8: While `valid_i` is low, `start_i`, `last_i`, `check_i` and `data_i` have no effect on the register or the outputs.
- R9: `crc_o` and `good_o` hold their values until the next word carrying `last_i` is accepted.
- R10: A word with `start_i` and `last_i` both high forms a complete one-word frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Data word is present this cycle |
| start_i | input | 1 | First word of a frame |
| last_i | input | 1 | Final word of a frame |
| check_i | input | 1 | 1 = check mode, 0 = generate mode (sampled on the last word) |
| data_i | input | DATA_W | Data word, bit 0 first on the line |
| crc_o | output | 32 | Complemented CRC of the latest frame |
| crc_valid_o | output | 1 | One-cycle strobe: a new result is present |
| good_o | output | 1 | Check-mode frame ended on the fixed residue |

## Verification
Random frames of 1 to 16 words are generated with idle gaps between words. During the gaps, garbage is driven on the data and control lines. Each result is compared with a bit-serial model. This separates a wrong XOR network or a wrong bit order from a register that reacts to idle cycles. Check-mode frames carry the model's check word, either intact or with one random bit flipped. This shows that the residue is detected at every frame length and that corruption is caught. Directed cases cover an all-zero word with a known value, single-word frames, and a frame that follows an abandoned one, which shows that the seed is reloaded.

// File: rtl/crc32_pkg.sv
package crc32_pkg;
  localparam int unsigned CRC_W = 32;
  typedef logic [CRC_W-1:0] crc_t;

  // reflected form of 0x04C11DB7
  localparam crc_t POLY_REFL = 32'hEDB88320;
  localparam crc_t SEED      = 32'hFFFFFFFF;
  // register content after data plus its own check word, reflected
  localparam crc_t RESIDUE   = 32'hDEBB20E3;

  typedef enum logic {
    MODE_GEN   = 1'b0,
    MODE_CHECK = 1'b1
  } mode_e;
endpackage

// File: rtl/crc32_xor_net.sv
module crc32_xor_net
  import crc32_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  crc_t              crc_i,
  input  logic [DATA_W-1:0] data_i,
  output crc_t              crc_o
);
  crc_t stage [DATA_W+1];

  assign stage[0] = crc_i;

  // one reflected shift per input bit; the chain flattens into an XOR net
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic fb;
    assign fb = stage[b][0] ^ data_i[b];
    assign stage[b+1] = {1'b0, stage[b][CRC_W-1:1]} ^ (fb ? POLY_REFL : '0);
  end

  assign crc_o = stage[DATA_W];
endmodule

// File: rtl/crc32_state.sv
module crc32_state
  import crc32_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output crc_t              crc_next_o
);
  crc_t crc_q;
  crc_t base;

  assign base = start_i ? SEED : crc_q;

  crc32_xor_net #(.DATA_W(DATA_W)) u_net (
    .crc_i  (base),
    .data_i (data_i),
    .crc_o  (crc_next_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= SEED;
    else if (valid_i) crc_q <= crc_next_o;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(crc_q)); // R8
endmodule

// File: rtl/crc32_result.sv
module crc32_result
  import crc32_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic check_i,
  input  crc_t crc_next_i,
  output crc_t crc_o,
  output logic crc_valid_o,
  output logic good_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_o       <= '0;
      crc_valid_o <= 1'b0;
      good_o      <= 1'b0;
    end else begin
      crc_valid_o <= fire_i;
      if (fire_i) begin
        crc_o  <= ~crc_next_i;
        good_o <= (mode_e'(check_i) == MODE_CHECK) && (crc_next_i == RESIDUE);
      end
    end
  end

  AST_STROBE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> crc_valid_o); // R4
  AST_STROBE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> !crc_valid_o); // R4
  AST_GOOD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_o |-> crc_o == ~RESIDUE); // R5
  AST_GOOD_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i && !check_i) |=> !good_o); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> ($stable(crc_o) && $stable(good_o))); // R9
endmodule

// File: rtl/crc32_frame_engine.sv
module crc32_frame_engine
  import crc32_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              start_i,
  input  logic              last_i,
  input  logic              check_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o,
  output logic              crc_valid_o,
  output logic              good_o
);
  crc_t crc_next;
  logic fire;

  assign fire = valid_i & last_i;

  crc32_state #(.DATA_W(DATA_W)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .start_i    (start_i),
    .data_i     (data_i),
    .crc_next_o (crc_next)
  );

  crc32_result u_result (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fire),
    .check_i     (check_i),
    .crc_next_i  (crc_next),
    .crc_o       (crc_o),
    .crc_valid_o (crc_valid_o),
    .good_o      (good_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!crc_valid_o && !good_o)); // R1
endmodule

// File: tb/tb_crc32_frame_engine.sv
module tb_crc32_frame_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0, start_i = 1'b0, last_i = 1'b0, check_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic [31:0] crc_o;
  logic crc_valid_o, good_o;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] fw [0:63];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  crc32_frame_engine #(.DATA_W(DW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .start_i(start_i),
    .last_i(last_i), .check_i(check_i), .data_i(data_i),
    .crc_o(crc_o), .crc_valid_o(crc_valid_o), .good_o(good_o)
  );

  // bit-serial reference over fw[0..n-1], returns the complemented value
  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int w = 0; w < n; w++)
      for (int b = 0; b < DW; b++) begin
        logic fb = c[0] ^ fw[w][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return ~c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic idle_garbage();
    @(negedge clk_i);
    valid_i = 1'b0; start_i = 1'($urandom); last_i = 1'($urandom);
    check_i = 1'($urandom); data_i = $urandom;
  endtask

  task automatic drive_frame(input int n, input bit chk, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps) while ($urandom_range(0, 2) == 0) idle_garbage();
      @(negedge clk_i);
      valid_i = 1'b1; start_i = (i == 0); last_i = (i == n - 1);
      check_i = chk; data_i = fw[i];
    end
    @(negedge clk_i);
    valid_i = 1'b0; start_i = 1'b0; last_i = 1'b0; check_i = 1'b0;
  endtask

  task automatic after_result(input logic [31:0] held_crc, input logic held_good);
    idle_garbage();
    check(crc_valid_o == 1'b0, "R4 strobe one cycle", 32'(crc_valid_o), 32'd0);
    check(crc_o == held_crc && good_o == held_good, "R9 hold / R8 idle ignored", crc_o, held_crc);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 32'd0, 32'd1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    logic [31:0] exp;
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check(crc_valid_o == 0 && good_o == 0 && crc_o == 0, "R1 in reset", crc_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(crc_valid_o == 0 && good_o == 0 && crc_o == 0, "R1 after reset", crc_o, 32'd0);

    // R3 R10: known value, one zero word
    fw[0] = 32'h0;
    drive_frame(1, 1'b0, 1'b0);
    check(crc_o == 32'h2144DF1C, "R3 zero word", crc_o, 32'h2144DF1C);
    check(crc_valid_o == 1'b1, "R4 strobe", 32'(crc_valid_o), 32'd1);
    check(good_o == 1'b0, "R7 gen mode", 32'(good_o), 32'd0);
    after_result(32'h2144DF1C, 1'b0);

    // R2: abandoned frame then fresh frame
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      valid_i = 1'b1; start_i = (i == 0); last_i = 1'b0; data_i = $urandom;
    end
    for (int i = 0; i < 4; i++) fw[i] = $urandom;
    exp = ref_crc(4);
    drive_frame(4, 1'b0, 1'b0);
    check(crc_o == exp, "R2 seed after abandoned frame", crc_o, exp);

    // R3 R7 R8: random generate frames with gaps
    for (int f = 0; f < 25; f++) begin
      n = $urandom_range(1, 16);
      for (int i = 0; i < n; i++) fw[i] = $urandom;
      exp = ref_crc(n);
      drive_frame(n, 1'b0, 1'b1);
      check(crc_o == exp, "R3 generate frame", crc_o, exp);
      check(good_o == 1'b0, "R7 gen mode good low", 32'(good_o), 32'd0);
      after_result(exp, 1'b0);
    end

    // R5 R6: check mode, intact or with one flipped bit
    for (int f = 0; f < 30; f++) begin
      bit bad = (f % 2 == 1);
      n = $urandom_range(1, 16);
      for (int i = 0; i < n; i++) fw[i] = $urandom;
      fw[n] = ref_crc(n);
      if (bad) begin
        int w = $urandom_range(0, n);
        fw[w][$urandom_range(0, 31)] ^= 1'b1;
      end
      exp = ref_crc(n + 1);
      drive_frame(n + 1, 1'b1, 1'b1);
      if (bad)
        check(good_o == 1'b0, "R6 corrupted frame rejected", 32'(good_o), 32'd0);
      else begin
        check(good_o == 1'b1, "R5 good frame accepted", 32'(good_o), 32'd1);
        check(crc_o == 32'h2144DF1C, "R5 residue complement", crc_o, 32'h2144DF1C);
      end
      check(crc_o == exp, "R3 check-mode value", crc_o, exp);
      after_result(exp, !bad);
    end

    // R10 R4: back-to-back one-word frames
    fw[0] = $urandom;
    exp = ref_crc(1);
    @(negedge clk_i);
    valid_i = 1'b1; start_i = 1'b1; last_i = 1'b1; check_i = 1'b0; data_i = fw[0];
    @(negedge clk_i);
    data_i = ~fw[0];
    check(crc_o == exp && crc_valid_o, "R10 single-word frame", crc_o, exp);
    fw[0] = ~fw[0];
    exp = ref_crc(1);
    @(negedge clk_i);
    valid_i = 1'b0; start_i = 1'b0; last_i = 1'b0;
    check(crc_o == exp && crc_valid_o, "R10 back-to-back frame", crc_o, exp);
    @(negedge clk_i);
    check(!crc_valid_o, "R4 strobe drops", 32'(crc_valid_o), 32'd0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule